// File: doc/BRIEF.md
# Bulk Endpoint DMA Termination Controller

This block runs one DMA channel between a system bus and a bulk endpoint of a full-speed USB device. It drives a request line, takes an acknowledge line and read or write strobes, and tracks a two-bank ping-pong endpoint buffer that can hold two packets. The direction is fixed per transfer. In the IN direction the bus writes bytes into the buffer and the packet engine takes whole packets out on an IN token. In the OUT direction the packet engine deposits whole received packets and the bus reads them out byte by byte. The buffer tracks occupancy and packet lengths only; the byte array sits beside it.

A transfer starts when software raises the enable bit. It ends on the first of four events: an external end-of-transfer input, the byte down-counter running out while counting is enabled, the last byte of a short OUT packet while short-packet stopping is enabled, or software dropping the enable. What happens next depends on the cause and the direction. An external stop on an OUT transfer discards the bank being read. Any stop on an IN transfer turns the bytes written so far into a packet. A one-cycle pulse and a sticky status word report which cause won.

Top module: `dma_term_ctrl`

## Requirements
- R1: `dreq` is high exactly when a transfer is active, `cfg_en` is high, `ext_eot` is low and the buffer is ready. For IN, ready means fewer than two committed packets are waiting. For OUT, ready means at least one committed packet is waiting.
- R2: A byte moves in a cycle where `dreq` is high and the strobe is present. In normal mode the strobe is `dack` together with `wr_stb` for IN or `rd_stb` for OUT. When `cfg_ack_only` is 1, `dack` alone is the strobe and `rd_stb`/`wr_stb` have no effect. `dack` without the matching strobe in normal mode moves nothing.
- R3: A rising edge of `cfg_en` loads `cfg_count` into a 16-bit down-counter, where 0 stands for 65536. Every byte decrements it. With `cfg_cnt_en`=1, the byte that brings the count to zero ends the transfer. With `cfg_cnt_en`=0 the count never ends it.
- R4: On an OUT transfer, `ext_eot` while active ends the transfer and discards the unread rest of the bank being read. The other bank keeps its packet.
- R5: On an IN transfer, any termination commits the bytes already written as a packet if there is at least one. An `in_token` pulse while a packet waits releases the oldest packet. In the cycle after the token, `tx_send` is high for one cycle and `tx_len` holds that packet's length.
- R6: On an IN transfer, the 64th byte of a bank commits it as a packet and switches to the other bank. The transfer goes on without a break if the other bank is free.
- R7: On an OUT transfer with `cfg_short_en`=1, reading the last byte of a packet shorter than 64 bytes ends the transfer. A 64-byte packet never does.
- R8: Lowering `cfg_en` while a transfer is active ends it.
- R9: `term_pulse` is high for one cycle, in the cycle after the ending edge, with exactly one bit set. Bit 0 is external, bit 1 is counter, bit 2 is short packet and bit 3 is software disable. When several causes coincide the lowest bit index wins.
- R10: `term_status` takes the same bit as the pulse, at the same edge, and keeps it. The edge that samples a rising `cfg_en` clears it.
- R11: On an OUT transfer, `rx_room` is high while a bank is free. An `rx_commit` with `rx_room` high stores a packet of `rx_len` bytes (1 to 64). An `rx_commit` with `rx_room` low is dropped. Packets are read in arrival order. `rx_room` is 0 when `cfg_dir_in`=1.
- R12: `ext_eot` while no transfer is active has no effect on status or buffers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | DMA enable; rising edge starts a transfer |
| cfg_cnt_en | input | 1 | Allow counter-based stop |
| cfg_short_en | input | 1 | Allow short-packet stop (OUT) |
| cfg_dir_in | input | 1 | 1 = IN (bus writes), 0 = OUT (bus reads) |
| cfg_ack_only | input | 1 | Acknowledge alone acts as strobe |
| cfg_count | input | 16 | Bytes to move; 0 means 65536 |
| dreq | output | 1 | DMA request |
| dack | input | 1 | DMA acknowledge |
| rd_stb | input | 1 | Bus read strobe |
| wr_stb | input | 1 | Bus write strobe |
| ext_eot | input | 1 | External end-of-transfer |
| rx_commit | input | 1 | Packet engine delivers an OUT packet |
| rx_len | input | 7 | Length of delivered OUT packet |
| rx_room | output | 1 | A bank is free for an OUT packet |
| in_token | input | 1 | IN token pulse from the packet engine |
| tx_send | output | 1 | A committed IN packet is released |
| tx_len | output | 7 | Length of the released IN packet |
| term_pulse | output | 4 | One-cycle ending cause |
| term_status | output | 4 | Sticky ending cause |

## Verification
The assertions assume that `rx_len` lies between 1 and 64. They also assume that direction and strobe mode change only while `cfg_en` is low, so a bank's bookkeeping never switches meaning in the middle of a transfer. The stimulus changes configuration only between transfers and delivers only packets of legal length. It drives strobes for fixed numbers of cycles, so the block itself decides which of them move bytes. A behavioural model built on packet queues follows every cycle, including refused packets and coinciding stop causes.

// File: rtl/dmaterm_pkg.sv
package dmaterm_pkg;
    localparam int CAUSE_N = 4;
    typedef enum logic [1:0] {
        CAUSE_EXT   = 2'd0,
        CAUSE_CNT   = 2'd1,
        CAUSE_SHORT = 2'd2,
        CAUSE_SW    = 2'd3
    } cause_e;
    typedef logic [CAUSE_N-1:0] cause_vec_t;
endpackage

// File: rtl/dt_bytecnt.sv
module dt_bytecnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last_hit
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    // the byte that empties the counter
    assign last_hit = dec && (cnt_q.cnt == W'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d.cnt = load_val;
        end else if (dec) begin
            cnt_d.cnt = cnt_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/dt_pingpong.sv
module dt_pingpong #(
    parameter int MPS   = 64,
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_in,
    input  logic             beat,
    input  logic             term_any,
    input  logic             flush,
    input  logic             rx_commit,
    input  logic [LEN_W-1:0] rx_len,
    input  logic             in_token,
    output logic             dma_ready,
    output logic             short_hit,
    output logic             rx_room,
    output logic             tx_send,
    output logic [LEN_W-1:0] tx_len
);
    localparam int NBANK = 2;
    localparam logic [LEN_W-1:0] MPS_L = LEN_W'(MPS);

    typedef struct packed {
        logic [NBANK-1:0]            full;
        logic [NBANK-1:0][LEN_W-1:0] len;
        logic                        prod;
        logic                        cons;
        logic [LEN_W-1:0]            part;
        logic                        tx_send;
        logic [LEN_W-1:0]            tx_len;
    } pp_t;

    pp_t pp_d, pp_q;
    logic [LEN_W-1:0] part_inc;
    logic             out_last;

    assign part_inc = pp_q.part + LEN_W'(beat);

    // outputs seen by the controller this cycle
    always_comb begin
        out_last  = !dir_in && beat && (part_inc == pp_q.len[pp_q.cons]);
        short_hit = out_last && (pp_q.len[pp_q.cons] < MPS_L);
        dma_ready = dir_in ? !pp_q.full[pp_q.prod] : pp_q.full[pp_q.cons];
        rx_room   = !dir_in && !pp_q.full[pp_q.prod];
    end

    always_comb begin
        pp_d         = pp_q;
        pp_d.tx_send = 1'b0;
        if (dir_in) begin
            // packet engine drains the oldest committed bank
            if (in_token && pp_q.full[pp_q.cons]) begin
                pp_d.full[pp_q.cons] = 1'b0;
                pp_d.cons            = !pp_q.cons;
                pp_d.tx_send         = 1'b1;
                pp_d.tx_len          = pp_q.len[pp_q.cons];
            end
            // bus fills the producer bank; full or stopped bank becomes a packet
            if (part_inc == MPS_L || (term_any && part_inc != '0)) begin
                pp_d.full[pp_q.prod] = 1'b1;
                pp_d.len[pp_q.prod]  = part_inc;
                pp_d.prod            = !pp_q.prod;
                pp_d.part            = '0;
            end else begin
                pp_d.part = part_inc;
            end
        end else begin
            // bus drains the consumer bank; last byte or flush frees it
            if (out_last || (flush && pp_q.full[pp_q.cons])) begin
                pp_d.full[pp_q.cons] = 1'b0;
                pp_d.cons            = !pp_q.cons;
                pp_d.part            = '0;
            end else begin
                pp_d.part = part_inc;
            end
            if (rx_commit && !pp_q.full[pp_q.prod]) begin
                pp_d.full[pp_q.prod] = 1'b1;
                pp_d.len[pp_q.prod]  = rx_len;
                pp_d.prod            = !pp_q.prod;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pp_q <= '0;
        end else begin
            pp_q <= pp_d;
        end
    end

    assign tx_send = pp_q.tx_send;
    assign tx_len  = pp_q.tx_len;

    p_part_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pp_q.part <= MPS_L)
        else $error("fill position beyond packet size");

    p_tx_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_send |-> (tx_len != '0 && tx_len <= MPS_L))
        else $error("released packet has illegal length");

    p_flush_other_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !dir_in && pp_q.full == 2'b11) |=> ($countones(pp_q.full) == 1))
        else $error("flush touched the idle bank");
endmodule

// File: rtl/dt_term_arb.sv
module dt_term_arb
    import dmaterm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cause_vec_t raw,
    input  logic       en_rise,
    output cause_vec_t win,
    output cause_vec_t pulse,
    output cause_vec_t sticky
);
    typedef struct packed {
        cause_vec_t pulse;
        cause_vec_t sticky;
    } arb_t;

    arb_t arb_d, arb_q;

    // lowest index wins
    always_comb begin
        win = '0;
        for (int i = CAUSE_N - 1; i >= 0; i--) begin
            if (raw[i]) begin
                win    = '0;
                win[i] = 1'b1;
            end
        end
    end

    always_comb begin
        arb_d.pulse  = win;
        arb_d.sticky = en_rise ? '0 : (arb_q.sticky | win);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arb_q <= '0;
        end else begin
            arb_q <= arb_d;
        end
    end

    assign pulse  = arb_q.pulse;
    assign sticky = arb_q.sticky;

    p_onehot_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulse))
        else $error("more than one ending cause reported");

    p_sticky_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> (sticky == '0))
        else $error("status survived a restart");
endmodule

// File: rtl/dma_term_ctrl.sv
module dma_term_ctrl
    import dmaterm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int MPS   = 64,
    localparam int LEN_W = $clog2(MPS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic               cfg_cnt_en,
    input  logic               cfg_short_en,
    input  logic               cfg_dir_in,
    input  logic               cfg_ack_only,
    input  logic [CNT_W-1:0]   cfg_count,
    output logic               dreq,
    input  logic               dack,
    input  logic               rd_stb,
    input  logic               wr_stb,
    input  logic               ext_eot,
    input  logic               rx_commit,
    input  logic [LEN_W-1:0]   rx_len,
    output logic               rx_room,
    input  logic               in_token,
    output logic               tx_send,
    output logic [LEN_W-1:0]   tx_len,
    output logic [CAUSE_N-1:0] term_pulse,
    output logic [CAUSE_N-1:0] term_status
);
    typedef struct packed {
        logic en_q;
        logic active;
    } ctl_t;

    ctl_t       ctl_d, ctl_q;
    logic       en_rise, strobe, beat, dma_ready, cnt_last, short_hit, term_any, flush;
    cause_vec_t raw, win;

    always_comb begin
        en_rise = cfg_en && !ctl_q.en_q;
        strobe  = cfg_ack_only ? dack : (dack && (cfg_dir_in ? wr_stb : rd_stb));
        dreq    = ctl_q.active && cfg_en && !ext_eot && dma_ready;
        beat    = dreq && strobe;
    end

    always_comb begin
        raw              = '0;
        raw[CAUSE_EXT]   = ctl_q.active && ext_eot;
        raw[CAUSE_CNT]   = cfg_cnt_en && cnt_last;
        raw[CAUSE_SHORT] = cfg_short_en && short_hit;
        raw[CAUSE_SW]    = ctl_q.active && !cfg_en;
    end

    assign term_any = |win;
    assign flush    = win[CAUSE_EXT] && !cfg_dir_in;

    always_comb begin
        ctl_d.en_q   = cfg_en;
        ctl_d.active = ctl_q.active;
        if (en_rise) begin
            ctl_d.active = 1'b1;
        end else if (term_any) begin
            ctl_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    dt_bytecnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (en_rise),
        .load_val (cfg_count),
        .dec      (beat),
        .last_hit (cnt_last)
    );

    dt_pingpong #(.MPS(MPS), .LEN_W(LEN_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_in    (cfg_dir_in),
        .beat      (beat),
        .term_any  (term_any),
        .flush     (flush),
        .rx_commit (rx_commit),
        .rx_len    (rx_len),
        .in_token  (in_token),
        .dma_ready (dma_ready),
        .short_hit (short_hit),
        .rx_room   (rx_room),
        .tx_send   (tx_send),
        .tx_len    (tx_len)
    );

    dt_term_arb u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw     (raw),
        .en_rise (en_rise),
        .win     (win),
        .pulse   (term_pulse),
        .sticky  (term_status)
    );

    p_dreq_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dreq |-> (cfg_en && !ext_eot))
        else $error("request raised while stopping");

    p_cnt_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        term_pulse[CAUSE_CNT] |-> !dreq)
        else $error("request after count ran out");

    p_short_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        term_pulse[CAUSE_SHORT] |-> !cfg_dir_in)
        else $error("short stop on an IN transfer");
endmodule

// File: tb/dma_term_ctrl_tb.sv
module dma_term_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 0, cfg_cnt_en = 0, cfg_short_en = 0, cfg_dir_in = 0, cfg_ack_only = 0;
    logic [15:0] cfg_count = '0;
    logic       dack = 0, rd_stb = 0, wr_stb = 0, ext_eot = 0;
    logic       rx_commit = 0, in_token = 0;
    logic [6:0] rx_len = '0;
    logic       dreq, rx_room, tx_send;
    logic [6:0] tx_len;
    logic [3:0] term_pulse, term_status;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = !clk;

    dma_term_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cnt_en(cfg_cnt_en),
        .cfg_short_en(cfg_short_en), .cfg_dir_in(cfg_dir_in), .cfg_ack_only(cfg_ack_only),
        .cfg_count(cfg_count), .dreq(dreq), .dack(dack), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .ext_eot(ext_eot), .rx_commit(rx_commit), .rx_len(rx_len), .rx_room(rx_room),
        .in_token(in_token), .tx_send(tx_send), .tx_len(tx_len),
        .term_pulse(term_pulse), .term_status(term_status)
    );

    // ---------------- behavioural reference ----------------
    bit         m_active, m_en_q, m_tx_send;
    int         m_cnt, m_part, m_rdpos, m_tx_len;
    int         q_in[$];
    int         q_out[$];
    logic [3:0] m_pulse, m_sticky;

    function automatic bit m_dreq();
        bit rdy;
        rdy = cfg_dir_in ? (q_in.size() < 2) : (q_out.size() > 0);
        return m_active && cfg_en && !ext_eot && rdy;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_en_q = 0; m_tx_send = 0; m_cnt = 0; m_part = 0; m_rdpos = 0;
            m_tx_len = 0; q_in.delete(); q_out.delete(); m_pulse = 0; m_sticky = 0;
        end else begin
            bit stb, bt, rise, room;
            logic [3:0] raw, win;
            int np;
            stb  = cfg_ack_only ? dack : (dack && (cfg_dir_in ? wr_stb : rd_stb));
            bt   = m_dreq() && stb;
            rise = cfg_en && !m_en_q;
            room = !cfg_dir_in && q_out.size() < 2;
            raw[0] = m_active && ext_eot;
            raw[1] = cfg_cnt_en && bt && (m_cnt == 1);
            raw[2] = !cfg_dir_in && cfg_short_en && bt && q_out.size() > 0
                     && (m_rdpos + 1 == q_out[0]) && q_out[0] < 64;
            raw[3] = m_active && !cfg_en;
            win = 0;
            for (int i = 3; i >= 0; i--) if (raw[i]) begin win = 0; win[i] = 1; end
            m_tx_send = 0;
            if (cfg_dir_in) begin
                if (in_token && q_in.size() > 0) begin
                    m_tx_len = q_in.pop_front();
                    m_tx_send = 1;
                end
                np = m_part + int'(bt);
                if (np == 64 || (win != 0 && np != 0)) begin
                    q_in.push_back(np);
                    m_part = 0;
                end else m_part = np;
            end else begin
                if (bt) begin
                    m_rdpos++;
                    if (m_rdpos == q_out[0]) begin void'(q_out.pop_front()); m_rdpos = 0; end
                end else if (win[0] && q_out.size() > 0) begin
                    void'(q_out.pop_front()); m_rdpos = 0;
                end
                if (rx_commit && room) q_out.push_back(int'(rx_len));
            end
            if (rise) m_cnt = int'(cfg_count);
            else if (bt) m_cnt = (m_cnt - 1) & 32'hFFFF;
            m_pulse  = win;
            m_sticky = rise ? 4'b0 : (m_sticky | win);
            m_active = rise ? 1'b1 : ((win != 0) ? 1'b0 : m_active);
            m_en_q   = cfg_en;
        end
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // cycle compare against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            check("R1 dreq", int'(dreq), int'(m_dreq()));
            check("R9 term_pulse", int'(term_pulse), int'(m_pulse));
            check("R10 term_status", int'(term_status), int'(m_sticky));
            check("R5 tx_send", int'(tx_send), int'(m_tx_send));
            if (m_tx_send) check("R5 tx_len", int'(tx_len), m_tx_len);
            check("R11 rx_room", int'(rx_room), int'(!cfg_dir_in && q_out.size() < 2));
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic start(bit dir, bit ce, bit se, bit ao, int cnt);
        cfg_dir_in = dir; cfg_cnt_en = ce; cfg_short_en = se; cfg_ack_only = ao;
        cfg_count = 16'(cnt);
        cfg_en = 1; tick(1);
    endtask

    task automatic stop();
        cfg_en = 0; tick(2);
    endtask

    task automatic hold(int n, bit with_stb);
        dack = 1;
        if (with_stb) begin
            if (cfg_dir_in) wr_stb = 1; else rd_stb = 1;
        end
        tick(n);
        dack = 0; wr_stb = 0; rd_stb = 0;
    endtask

    task automatic push_rx(int len);
        rx_commit = 1; rx_len = 7'(len); tick(1); rx_commit = 0;
    endtask

    task automatic token();
        in_token = 1; tick(1); in_token = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        finish_run();
    end

    initial begin
        tick(3); rst_n = 1; tick(1);
        check("R1 reset dreq", int'(dreq), 0);
        check("R10 reset status", int'(term_status), 0);
        check("R11 reset room", int'(rx_room), 1);

        // R3 + R5: counter stop on IN, partial packet released by token
        start(1, 1, 0, 0, 10); hold(15, 1);
        check("R3 count stop", int'(term_status), 4'b0010);
        stop(); token();
        check("R5 tx_send", int'(tx_send), 1);
        check("R5 tx_len partial", int'(tx_len), 10);
        tick(1);

        // R2: acknowledge without write strobe moves nothing in normal mode
        start(1, 1, 0, 0, 3); hold(5, 0);
        check("R2 no strobe no stop", int'(term_status), 0);
        stop();
        check("R8 sw stop", int'(term_status), 4'b1000);
        token();
        check("R2 nothing written", int'(tx_send), 0);
        // R2: acknowledge-only mode
        start(1, 1, 0, 1, 3); hold(5, 0);
        check("R2 ack only stop", int'(term_status), 4'b0010);
        stop(); token();
        check("R2 ack only len", int'(tx_len), 3);
        tick(1);

        // R6: auto commit at 64 and continue
        start(1, 0, 0, 0, 0); hold(70, 1);
        check("R6 continues", int'(dreq), 1);
        stop();
        check("R8 sw stop IN", int'(term_status), 4'b1000);
        token(); check("R6 full packet", int'(tx_len), 64);
        token(); check("R5 tail packet", int'(tx_len), 6);
        // R1: both banks full blocks the request
        start(1, 0, 0, 0, 0); hold(130, 1);
        check("R1 both full", int'(dreq), 0);
        stop(); token(); token(); tick(1);

        // R7: short and full OUT packets
        cfg_dir_in = 0; tick(1);
        push_rx(5); start(0, 0, 1, 0, 0); hold(8, 1);
        check("R7 short stop", int'(term_status), 4'b0100);
        stop();
        push_rx(64); start(0, 0, 1, 0, 0); hold(70, 1);
        check("R7 full no stop", int'(term_status), 0);
        check("R7 drained", int'(dreq), 0);
        stop();

        // R11 + R4: refused third packet, flush keeps other bank
        push_rx(10); push_rx(20);
        check("R11 no room", int'(rx_room), 0);
        push_rx(7);
        start(0, 0, 1, 0, 0); hold(3, 1);
        ext_eot = 1; tick(1); ext_eot = 0;
        check("R4 ext stop", int'(term_status), 4'b0001);
        stop();
        start(0, 0, 1, 0, 0); hold(25, 1);
        check("R4 other bank kept", int'(term_status), 4'b0100);
        check("R11 refused dropped", int'(dreq), 0);
        stop();

        // R9: counter beats short; external beats software
        push_rx(4); start(0, 1, 1, 0, 4); hold(6, 1);
        check("R9 count over short", int'(term_status), 4'b0010);
        stop();
        start(1, 0, 0, 0, 0);
        cfg_en = 0; ext_eot = 1; tick(1); ext_eot = 0;
        check("R9 ext over sw", int'(term_status), 4'b0001);
        tick(2);

        // R12: external stop while idle
        ext_eot = 1; tick(2); ext_eot = 0;
        check("R12 idle ext", int'(term_status), 4'b0001);
        check("R12 idle dreq", int'(dreq), 0);
        start(1, 0, 0, 0, 0);
        check("R10 cleared on start", int'(term_status), 0);
        stop(); tick(2);

        finish_run();
    end
endmodule